// File: doc/BRIEF.md
# Scan-Side Debug Mailbox Register

This block is a data register hung off a JTAG test access port. Through it an external debugger trades 32-bit words with an on-chip processor. One scan frame carries a direction bit, a register address and a data word. The block acts on the frame only when the TAP strobes the update step. A read request therefore latches the selected value at that update, and the debugger collects it by shifting out the next frame.

Two registers are decoded. The first is a status register that the scan side can only read. One of its bits tells the debugger whether the processor has left a word for it. The second is a mailbox data register that carries words in both directions:
- The processor writes a word into it with a write strobe, which raises the word-available flag.
- A scan read of it returns that word and drops the flag.
- A scan write to it hands the shifted-in word to the processor as a single-cycle valid pulse.

Everything runs on TCK. The capture, shift and update strobes come from an external TAP state machine.

Top module: `dbgc_top`

## Requirements
- R1: After reset the word-available flag is 0, the valid pulse to the processor is 0, and the data field captured by the first scan is all zeros.
- R2: The chain is 38 bits long and shifts from TDI toward TDO, with TDO showing chain bit 0. Chain bits 31:0 hold the data word, 36:32 hold the address and bit 37 holds the direction, where 1 means write and 0 means read. The debugger therefore shifts data bit 0 first and the direction bit last. A capture loads the read latch into bits 31:0 and zeros into bits 37:32. A bit shifted in appears at TDO 38 shifts later.
- R3: A write frame (direction 1) to address 0x05 raises the valid output for exactly the one cycle after the update strobe. The data output carries the frame's 32-bit word during that cycle.
- R4: A read frame (direction 0) copies the selected register into the read latch at the update strobe. The next scan's capture returns that value in bits 31:0.
- R5: A read of address 0x04 returns the status word. Its bit 1 is the word-available flag, where 1 means ready and 0 means busy, and all its other bits are 0.
- R6: A processor write strobe sets the flag and stores its word in the mailbox. A scan read of address 0x05 returns the stored word and clears the flag. If the processor strobe falls in the same cycle as that read's update, the flag stays set, the mailbox takes the new word and the read returns the old one.
- R7: Write frames to address 0x04 or to any undecoded address are ignored. They produce no valid pulse, and they leave the flag and the mailbox unchanged.
- R8: A read frame to an undecoded address loads zero into the read latch.
- R9: Capture and shift without an update strobe change neither the read latch nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| capture_dr | input | 1 | TAP capture strobe |
| shift_dr | input | 1 | TAP shift strobe |
| update_dr | input | 1 | TAP update strobe |
| cpu_wr | input | 1 | Processor write strobe into the mailbox |
| cpu_wdata | input | 32 | Processor word |
| word_avail | output | 1 | Word-available flag |
| h2c_valid | output | 1 | One-cycle pulse for a word from the debugger |
| h2c_data | output | 32 | Word from the debugger |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit address, status register at 0x04, mailbox at 0x05, flag in bit 1 and a combinational TDO. The bench samples TDO half a cycle after each edge, so the same bench also works with the falling-edge retimed TDO variant. The defaults bring within reach the following:
- frames longer than the chain, which show its length;
- processor strobes that land exactly on a clearing update;
- random addresses across the whole 5-bit space, most of them undecoded.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;
endpackage

// File: rtl/dbgc_scan.sv
module dbgc_scan #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 5,
   parameter bit TDO_RETIME = 1'b0,
   localparam int CH_W      = DATA_W + ADDR_W + 1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tdi,
   input  logic              capture,
   input  logic              shift,
   input  logic [DATA_W-1:0] cap_data,
   output logic [CH_W-1:0]   chain,
   output logic              tdo
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else if (capture) begin
         chain <= {{(ADDR_W+1){1'b0}}, cap_data};
      end else if (shift) begin
         chain <= {tdi, chain[CH_W-1:1]};
      end
   end

   generate
      if (TDO_RETIME) begin : g_tdo_neg
         logic tdo_q;
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n) tdo_q <= 1'b0;
            else        tdo_q <= chain[0];
         end
         assign tdo = tdo_q;
      end else begin : g_tdo_comb
         assign tdo = chain[0];
      end
   endgenerate

   // R2
   cap_hdr_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
      capture |=> (chain[CH_W-1:DATA_W] == '0));
   // R2
   cap_data_chk: assert property (@(posedge tck) disable iff (!rst_n)
      capture |=> (chain[DATA_W-1:0] == $past(cap_data)));
endmodule

// File: rtl/dbgc_regs.sv
module dbgc_regs
   import dbgc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 4,
   parameter int DATA_ADDR = 5,
   parameter int FLAG_BIT  = 1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              update,
   input  dir_e              req_dir,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] rd_latch,
   output logic              flag,
   output logic              h2c_valid,
   output logic [DATA_W-1:0] h2c_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

   logic [DATA_W-1:0] mbox;
   logic [DATA_W-1:0] status_w;
   logic [DATA_W-1:0] rd_sel;
   logic              hit_ctrl, hit_data, do_rd, do_wr, rd_clear;

   assign hit_ctrl = (req_addr == A_CTRL);
   assign hit_data = (req_addr == A_DATA);
   assign do_rd    = update && (req_dir == DIR_RD);
   assign do_wr    = update && (req_dir == DIR_WR) && hit_data;
   assign rd_clear = do_rd && hit_data;

   always_comb begin
      status_w           = '0;
      status_w[FLAG_BIT] = flag;
      if (hit_ctrl)      rd_sel = status_w;
      else if (hit_data) rd_sel = mbox;
      else               rd_sel = '0;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         rd_latch  <= '0;
         flag      <= 1'b0;
         mbox      <= '0;
         h2c_valid <= 1'b0;
         h2c_data  <= '0;
      end else begin
         h2c_valid <= do_wr;
         if (do_wr) h2c_data <= req_data;
         if (do_rd) rd_latch <= rd_sel;
         if (cpu_wr) begin
            mbox <= cpu_wdata;
            flag <= 1'b1;
         end else if (rd_clear) begin
            flag <= 1'b0;
         end
      end
   end

   // R6
   flag_set_chk: assert property (@(posedge tck) disable iff (!rst_n)
      cpu_wr |=> flag);
   // R6
   flag_clr_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (update && req_dir == DIR_RD && req_addr == A_DATA && !cpu_wr) |=> !flag);
   // R3
   pulse_src_chk: assert property (@(posedge tck) disable iff (!rst_n)
      h2c_valid |-> $past(update));
   // R7
   ignored_wr_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (update && req_dir == DIR_WR && req_addr != A_DATA) |=> !h2c_valid);
   // R9
   latch_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
      !update |=> $stable(rd_latch));
   // R9
   flag_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (!update && !cpu_wr) |=> $stable(flag));
endmodule

// File: rtl/dbgc_top.sv
module dbgc_top
   import dbgc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 5,
   parameter int CTRL_ADDR  = 4,
   parameter int DATA_ADDR  = 5,
   parameter int FLAG_BIT   = 1,
   parameter bit TDO_RETIME = 1'b0
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tdi,
   output logic              tdo,
   input  logic              capture_dr,
   input  logic              shift_dr,
   input  logic              update_dr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              word_avail,
   output logic              h2c_valid,
   output logic [DATA_W-1:0] h2c_data
);
   localparam int CH_W = DATA_W + ADDR_W + 1;

   generate
      if (FLAG_BIT >= DATA_W) begin : g_bad_flag
         $error("flag bit lies outside the data word");
      end
      if (CTRL_ADDR == DATA_ADDR) begin : g_bad_map
         $error("status and mailbox addresses collide");
      end
      if (CTRL_ADDR >= (1 << ADDR_W) || DATA_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address does not fit the address field");
      end
   endgenerate

   logic [CH_W-1:0]   chain;
   logic [DATA_W-1:0] rd_latch;
   dir_e              req_dir;

   assign req_dir = dir_e'(chain[CH_W-1]);

   dbgc_scan #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TDO_RETIME(TDO_RETIME)
   ) u_scan (
      .tck(tck), .rst_n(rst_n), .tdi(tdi),
      .capture(capture_dr), .shift(shift_dr),
      .cap_data(rd_latch), .chain(chain), .tdo(tdo)
   );

   dbgc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
      .DATA_ADDR(DATA_ADDR), .FLAG_BIT(FLAG_BIT)
   ) u_regs (
      .tck(tck), .rst_n(rst_n), .update(update_dr),
      .req_dir(req_dir), .req_addr(chain[CH_W-2:DATA_W]),
      .req_data(chain[DATA_W-1:0]),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .rd_latch(rd_latch), .flag(word_avail),
      .h2c_valid(h2c_valid), .h2c_data(h2c_data)
   );

   // R1
   rst_quiet_chk: assert property (@(posedge tck)
      $rose(rst_n) |-> (!word_avail && !h2c_valid));
endmodule

// File: tb/dbgc_top_test.sv
module dbgc_top_test;
   logic tck = 1'b0;
   logic rst_n = 1'b0;
   logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic cpu_wr = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic tdo, word_avail, h2c_valid;
   logic [31:0] h2c_data;

   always #10 tck = ~tck;

   dbgc_top uut (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .word_avail(word_avail),
      .h2c_valid(h2c_valid), .h2c_data(h2c_data)
   );

   int n_chk = 0, n_bad = 0;

   // model of the requirements
   logic [31:0] m_latch = '0, m_mbox = '0;
   logic        m_flag = 1'b0;

   logic [75:0] sout;
   logic        pv0, pv1;
   logic [31:0] pd0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [37:0] mk(input logic rw, input logic [4:0] a, input logic [31:0] d);
      return {rw, a, d};
   endfunction

   task automatic cpu_put(input logic [31:0] d);
      @(posedge tck); #5 cpu_wr = 1'b1; cpu_wdata = d;
      @(posedge tck); #5 cpu_wr = 1'b0;
      m_mbox = d; m_flag = 1'b1;
   endtask

   // capture, len shifts, optional update (with optional processor strobe on it)
   task automatic scan(input logic [75:0] din, input int len, input bit upd,
                       input bit cpu_same, input logic [31:0] cpu_d);
      @(posedge tck); #5 capture_dr = 1'b1;
      @(posedge tck); #5 capture_dr = 1'b0; shift_dr = 1'b1;
      sout = '0;
      for (int i = 0; i < len; i++) begin
         tdi = din[i];
         @(negedge tck); #5 sout[i] = tdo;
         @(posedge tck); #5;
      end
      shift_dr = 1'b0;
      if (upd) begin
         update_dr = 1'b1;
         if (cpu_same) begin cpu_wr = 1'b1; cpu_wdata = cpu_d; end
         @(posedge tck); #5 update_dr = 1'b0; cpu_wr = 1'b0;
      end
      pv0 = h2c_valid; pd0 = h2c_data;
      @(posedge tck); #5 pv1 = h2c_valid;
   endtask

   // full 38-bit frame with model update and checks
   task automatic frame(input string req, input logic rw, input logic [4:0] a,
                        input logic [31:0] d, input bit cpu_same, input logic [31:0] cpu_d);
      logic [31:0] exp_out;
      bit          exp_pulse;
      exp_out = m_latch;
      scan({38'b0, mk(rw, a, d)}, 38, 1'b1, cpu_same, cpu_d);
      exp_pulse = (rw == 1'b1) && (a == 5'd5);
      if (rw == 1'b0) begin
         if (a == 5'd4)      m_latch = {30'b0, m_flag, 1'b0};
         else if (a == 5'd5) m_latch = m_mbox;
         else                m_latch = '0;
         if (a == 5'd5) m_flag = 1'b0;
      end
      if (cpu_same) begin m_flag = 1'b1; m_mbox = cpu_d; end
      chk({req, " data field"}, {32'b0, sout[31:0]}, {32'b0, exp_out});
      chk({req, " R2 header zero"}, {58'b0, sout[37:32]}, 64'd0);
      chk({req, " pulse"}, {62'b0, pv0, pv1}, {62'b0, exp_pulse, 1'b0});
      if (exp_pulse) chk({req, " R3 h2c word"}, {32'b0, pd0}, {32'b0, d});
      chk({req, " flag"}, {63'b0, word_avail}, {63'b0, m_flag});
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      logic [4:0]  ua;
      void'($urandom(32'd4711));
      repeat (3) @(posedge tck);
      #5 rst_n = 1'b1;
      #1;
      // R1
      chk("R1 flag at reset", {63'b0, word_avail}, 64'd0);
      chk("R1 pulse at reset", {63'b0, h2c_valid}, 64'd0);
      frame("R1 first capture", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      // R5 status busy
      frame("R5 status busy", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      chk("R5 status value busy", {32'b0, m_latch}, 64'd0);
      // R6 / R4 / R5
      a = $urandom;
      cpu_put(a);
      chk("R6 flag set by cpu", {63'b0, word_avail}, 64'd1);
      frame("R5 req status", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      frame("R5 status ready", 1'b0, 5'd5, 32'h0, 1'b0, '0);
      chk("R5 ready encoding", {32'b0, sout[31:0]}, 64'h2);
      chk("R6 flag cleared by read", {63'b0, word_avail}, 64'd0);
      frame("R4 read returns mailbox", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      chk("R4 mailbox word", {32'b0, sout[31:0]}, {32'b0, a});
      frame("R5 status after clear", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      // R3
      b = $urandom;
      frame("R3 write mailbox", 1'b1, 5'd5, b, 1'b0, '0);
      // R7
      cpu_put($urandom);
      frame("R7 write status", 1'b1, 5'd4, 32'hFFFF_FFFF, 1'b0, '0);
      frame("R7 write undecoded", 1'b1, 5'd17, $urandom, 1'b0, '0);
      frame("R7 mailbox intact", 1'b0, 5'd5, 32'h0, 1'b0, '0);
      frame("R7 mailbox readback", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      chk("R7 mailbox word unchanged", {32'b0, sout[31:0]}, {32'b0, m_mbox});
      // R8
      cpu_put(32'hA5A5_0001);
      frame("R8 prime latch", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      frame("R8 read undecoded", 1'b0, 5'd30, 32'h0, 1'b0, '0);
      frame("R8 undecoded returns zero", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      chk("R8 zero word", {32'b0, sout[31:0]}, 64'd0);
      // R9: no update
      frame("R9 prime", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      scan({38'b0, mk(1'b0, 5'd5, 32'h0)}, 38, 1'b0, 1'b0, '0);
      chk("R9 flag kept", {63'b0, word_avail}, {63'b0, m_flag});
      frame("R9 latch kept", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      // R2 chain length
      a = $urandom;
      scan({28'b0, 10'h2B7, a, 6'b0}, 48, 1'b0, 1'b0, '0);
      chk("R2 chain length", {54'b0, sout[47:38]}, {54'b0, a[3:0], 6'b0});
      // R6 simultaneous strobe and clearing read
      cpu_put(32'h1111_2222);
      frame("R6 collide", 1'b0, 5'd5, 32'h0, 1'b1, 32'h3333_4444);
      chk("R6 flag stays set", {63'b0, word_avail}, 64'd1);
      frame("R6 collide old word", 1'b0, 5'd5, 32'h0, 1'b0, '0);
      chk("R6 old word returned", {32'b0, sout[31:0]}, 64'h1111_2222);
      frame("R6 new word", 1'b0, 5'd4, 32'h0, 1'b0, '0);
      chk("R6 new word returned", {32'b0, sout[31:0]}, 64'h3333_4444);
      // random mix
      for (int k = 0; k < 60; k++) begin
         case ($urandom % 4)
            0: cpu_put($urandom);
            1: frame("R4 random read", 1'b0, (($urandom % 2) != 0) ? 5'd4 : 5'd5,
                     $urandom, 1'b0, '0);
            2: frame("R3 random write", 1'b1, 5'd5, $urandom, 1'b0, '0);
            default: begin
               ua = 5'($urandom);
               frame("R7 R8 random addr", 1'($urandom), ua, $urandom,
                     (($urandom % 5) == 0), $urandom);
            end
         endcase
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule